// File: doc/BRIEF.md
# Load I/O Instruction Sequencer

This block runs a single-address load-I/O instruction. On a start pulse it captures the operand address and the Q code. A Q code of zero ends the instruction with no effect. Any other Q code makes the sequencer test the addressed device. While the device reports busy or needs attention, the sequencer stays on the instruction and raises a retry request every cycle, as a start-I/O does. Once the device is free, the sequencer runs two storage byte cycles. The first byte goes into the high half of the target register and the second byte into the low half.

The device attachment picks the target register on its select lines. The top bit of the select tells where the register is. When it is 1 the register is a CPU local storage register. When it is 0 the register is in the attachment. The lower bits give the register index. Storage reads use a valid/ready request channel: the sequencer holds `sto_req` with a stable `sto_addr` until `sto_gnt` is seen high at a clock edge. It issues the next request only after the read data has come back. Read data arrives on `sto_rvalid`/`sto_rdata`, at least one cycle after the grant, one response per grant. The sequencer accepts that response in any cycle, so the return path has no ready signal.

Top module: `lio_seq`

## Requirements
- R1: After synchronous reset the sequencer is idle: `sto_req`, `retry`, `done` and all four write strobes are low.
- R2: A start pulse is accepted only while idle. It captures `opnd_addr` and `qcode`. A start pulse during an instruction is ignored and changes neither the addresses used nor the number of `done` pulses.
- R3: When the captured Q code is zero, `done` pulses once, in the second cycle after the start cycle. No storage request, retry or register write occurs, whatever the device status.
- R4: With a nonzero Q code, `retry` is high in every cycle in which the device reports busy or attention. No storage request is made in those cycles. The sequencer leaves this check in the cycle after both status inputs are low.
- R5: The first storage request carries the captured operand address. While `sto_gnt` is low, `sto_req` stays high and `sto_addr` does not change.
- R6: The second storage request carries the operand address plus one, wrapping modulo 2^AW.
- R7: The first returned byte raises a one-cycle write-high strobe. The second returned byte raises a one-cycle write-low strobe. `wr_data` equals the returned byte in each strobe cycle, and write-low never comes before write-high.
- R8: `reg_sel` is sampled in the cycle in which the device check passes. If its top bit is 1, only `lsr_wr_hi`/`lsr_wr_lo` fire. If its top bit is 0, only `att_wr_hi`/`att_wr_lo` fire. `wr_index` equals the lower bits of `reg_sel`.
- R9: `done` is a single-cycle pulse in the cycle after the write-low strobe. The sequencer then accepts a new start.
- R10: At most one storage read is outstanding. No request is raised between a grant and the return of its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an instruction (accepted while idle) |
| opnd_addr | input | AW | Operand storage address |
| qcode | input | QW | Q code; zero means no operation |
| dev_busy | input | 1 | Addressed device is busy |
| dev_attn | input | 1 | Addressed device needs attention |
| reg_sel | input | SW | Target register select from the attachment; top bit 1 = CPU local register |
| sto_req | output | 1 | Storage read request valid |
| sto_gnt | input | 1 | Storage read request ready |
| sto_addr | output | AW | Storage byte address |
| sto_rvalid | input | 1 | Read data valid |
| sto_rdata | input | 8 | Read data byte |
| lsr_wr_hi | output | 1 | Write high half of CPU local register |
| lsr_wr_lo | output | 1 | Write low half of CPU local register |
| att_wr_hi | output | 1 | Write high half of attachment register |
| att_wr_lo | output | 1 | Write low half of attachment register |
| wr_index | output | SW-1 | Index of the target register |
| wr_data | output | 8 | Byte to write |
| retry | output | 1 | Device not ready; instruction loops |
| done | output | 1 | Instruction complete pulse |

## Verification
The assertions assume that storage answers each grant with exactly one `sto_rvalid`, no earlier than the cycle after the grant, and never without a grant. They also assume that `reg_sel` stays steady while the device check is passing. The bench storage model registers every grant before it replies, with a set latency, and it stalls the grant only through a counter that reloads on each start. The bench changes the device status and select lines only between instructions or after a falling edge, so every input is steady around each sampling edge.

// File: rtl/lio_pkg.sv
package lio_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CHECK = 3'd1,
    S_CYC1  = 3'd2,
    S_CYC2  = 3'd3,
    S_DONE  = 3'd4
  } lio_state_t;
endpackage

// File: rtl/lio_ctrl.sv
module lio_ctrl
  import lio_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic q_zero,
  input  logic dev_busy,
  input  logic dev_attn,
  input  logic sto_gnt,
  input  logic sto_rvalid,
  output logic cap_en,
  output logic take_sel,
  output logic second,
  output logic sto_req,
  output logic byte_hi,
  output logic byte_lo,
  output logic retry,
  output logic done
);
  lio_state_t state;
  logic       issued;   // request granted, awaiting data
  logic       blocked;

  assign blocked = dev_busy | dev_attn;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      issued <= 1'b0;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_CHECK;
        S_CHECK: begin
          if (q_zero)        state <= S_DONE;
          else if (!blocked) state <= S_CYC1;
        end
        S_CYC1, S_CYC2: begin
          if (!issued && sto_gnt) issued <= 1'b1;
          if (issued && sto_rvalid) begin
            issued <= 1'b0;
            state  <= (state == S_CYC1) ? S_CYC2 : S_DONE;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cap_en   = (state == S_IDLE) && start;
    take_sel = (state == S_CHECK) && !q_zero && !blocked;
    retry    = (state == S_CHECK) && !q_zero && blocked;
    second   = (state == S_CYC2);
    sto_req  = ((state == S_CYC1) || (state == S_CYC2)) && !issued;
    byte_hi  = (state == S_CYC1) && issued && sto_rvalid;
    byte_lo  = (state == S_CYC2) && issued && sto_rvalid;
    done     = (state == S_DONE);
  end
endmodule

// File: rtl/lio_capture.sv
module lio_capture #(
  parameter int AW = 16,
  parameter int QW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic          take_sel,
  input  logic          second,
  input  logic [AW-1:0] opnd_addr,
  input  logic [QW-1:0] qcode,
  input  logic [SW-1:0] reg_sel,
  output logic          q_zero,
  output logic [AW-1:0] sto_addr,
  output logic [SW-1:0] sel_q
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      q_zero <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (cap_en) begin
        base_q <= opnd_addr;
        q_zero <= (qcode == '0);
      end
      if (take_sel) sel_q <= reg_sel;
    end
  end

  // second byte sits at the next address, wrapping across the top
  assign sto_addr = second ? base_q + AW'(1) : base_q;
endmodule

// File: rtl/lio_steer.sv
module lio_steer #(
  parameter int SW = 4
) (
  input  logic [SW-1:0] sel_q,
  input  logic          byte_hi,
  input  logic          byte_lo,
  input  logic [7:0]    sto_rdata,
  output logic          lsr_wr_hi,
  output logic          lsr_wr_lo,
  output logic          att_wr_hi,
  output logic          att_wr_lo,
  output logic [SW-2:0] wr_index,
  output logic [7:0]    wr_data
);
  localparam int LOC_BIT = SW - 1;
  logic to_cpu;

  assign to_cpu    = sel_q[LOC_BIT];
  assign lsr_wr_hi = byte_hi &&  to_cpu;
  assign lsr_wr_lo = byte_lo &&  to_cpu;
  assign att_wr_hi = byte_hi && !to_cpu;
  assign att_wr_lo = byte_lo && !to_cpu;
  assign wr_index  = sel_q[LOC_BIT-1:0];
  assign wr_data   = sto_rdata;
endmodule

// File: rtl/lio_seq.sv
module lio_seq #(
  parameter int AW = 16,
  parameter int QW = 8,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] opnd_addr,
  input  logic [QW-1:0] qcode,
  input  logic          dev_busy,
  input  logic          dev_attn,
  input  logic [SW-1:0] reg_sel,
  output logic          sto_req,
  input  logic          sto_gnt,
  output logic [AW-1:0] sto_addr,
  input  logic          sto_rvalid,
  input  logic [7:0]    sto_rdata,
  output logic          lsr_wr_hi,
  output logic          lsr_wr_lo,
  output logic          att_wr_hi,
  output logic          att_wr_lo,
  output logic [SW-2:0] wr_index,
  output logic [7:0]    wr_data,
  output logic          retry,
  output logic          done
);
  logic          cap_en, take_sel, second, q_zero, byte_hi, byte_lo;
  logic [SW-1:0] sel_q;

  lio_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .q_zero(q_zero),
    .dev_busy(dev_busy), .dev_attn(dev_attn),
    .sto_gnt(sto_gnt), .sto_rvalid(sto_rvalid),
    .cap_en(cap_en), .take_sel(take_sel), .second(second),
    .sto_req(sto_req), .byte_hi(byte_hi), .byte_lo(byte_lo),
    .retry(retry), .done(done)
  );

  lio_capture #(.AW(AW), .QW(QW), .SW(SW)) u_cap (
    .clk(clk), .rst(rst), .cap_en(cap_en), .take_sel(take_sel),
    .second(second), .opnd_addr(opnd_addr), .qcode(qcode),
    .reg_sel(reg_sel), .q_zero(q_zero), .sto_addr(sto_addr),
    .sel_q(sel_q)
  );

  lio_steer #(.SW(SW)) u_steer (
    .sel_q(sel_q), .byte_hi(byte_hi), .byte_lo(byte_lo),
    .sto_rdata(sto_rdata),
    .lsr_wr_hi(lsr_wr_hi), .lsr_wr_lo(lsr_wr_lo),
    .att_wr_hi(att_wr_hi), .att_wr_lo(att_wr_lo),
    .wr_index(wr_index), .wr_data(wr_data)
  );
endmodule

// File: rtl/lio_seq_chk.sv
module lio_seq_chk #(
  parameter int AW = 16,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          sto_req,
  input logic          sto_gnt,
  input logic [AW-1:0] sto_addr,
  input logic          lsr_wr_hi,
  input logic          lsr_wr_lo,
  input logic          att_wr_hi,
  input logic          att_wr_lo,
  input logic [SW-2:0] wr_index,
  input logic          retry,
  input logic          done
);
  logic hi_seen;
  logic any_hi, any_lo;
  assign any_hi = lsr_wr_hi || att_wr_hi;
  assign any_lo = lsr_wr_lo || att_wr_lo;

  always_ff @(posedge clk) begin
    if (rst)         hi_seen <= 1'b0;
    else if (any_hi) hi_seen <= 1'b1;
    else if (done)   hi_seen <= 1'b0;
  end

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (sto_req && !sto_gnt) |=> (sto_req && $stable(sto_addr)));

  p_single_out_r10: assert property (@(posedge clk) disable iff (rst)
    (sto_req && sto_gnt) |=> !sto_req);

  p_no_req_retry_r4: assert property (@(posedge clk) disable iff (rst)
    retry |-> !sto_req);

  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lsr_wr_hi, lsr_wr_lo, att_wr_hi, att_wr_lo}));

  p_lo_after_hi_r7: assert property (@(posedge clk) disable iff (rst)
    any_lo |-> hi_seen);

  p_done_follows_lo_r9: assert property (@(posedge clk) disable iff (rst)
    any_lo |=> done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_index_steady_r8: assert property (@(posedge clk) disable iff (rst)
    (any_hi || any_lo) |=> (!(any_hi || any_lo) || $stable(wr_index)));
endmodule

bind lio_seq lio_seq_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .sto_req(sto_req), .sto_gnt(sto_gnt),
  .sto_addr(sto_addr), .lsr_wr_hi(lsr_wr_hi), .lsr_wr_lo(lsr_wr_lo),
  .att_wr_hi(att_wr_hi), .att_wr_lo(att_wr_lo), .wr_index(wr_index),
  .retry(retry), .done(done)
);

// File: tb/lio_seq_test.sv
`timescale 1ns/1ps
module lio_seq_test;
  localparam int AW = 16, QW = 8, SW = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] opnd_addr = '0;
  logic [QW-1:0] qcode = '0;
  logic dev_busy = 1'b0, dev_attn = 1'b0;
  logic [SW-1:0] reg_sel = '0;
  logic sto_req, sto_gnt, sto_rvalid;
  logic [AW-1:0] sto_addr;
  logic [7:0] sto_rdata, wr_data;
  logic lsr_wr_hi, lsr_wr_lo, att_wr_hi, att_wr_lo, retry, done;
  logic [SW-2:0] wr_index;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  lio_seq #(.AW(AW), .QW(QW), .SW(SW)) uut (.*);

  function automatic logic [7:0] mem_b(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd3;
    t = t + a[15:8];
    return t ^ 8'hA5;
  endfunction

  // storage model: grant with optional stall, respond after latency
  int stall_cfg = 0, lat = 0, stall_used = 0, rsp_wait = 0;
  logic rsp_pend = 1'b0;
  logic [AW-1:0] rsp_addr = '0;
  initial begin sto_gnt = 1'b1; sto_rvalid = 1'b0; sto_rdata = '0; end

  always @(posedge clk) begin
    sto_rvalid <= 1'b0;
    if (start) begin
      stall_used <= 0;
      sto_gnt    <= (stall_cfg == 0);
    end else if (sto_req && !sto_gnt) begin
      stall_used <= stall_used + 1;
      sto_gnt    <= (stall_used + 1 >= stall_cfg);
    end
    if (rsp_pend) begin
      if (rsp_wait == 0) begin
        sto_rvalid <= 1'b1;
        sto_rdata  <= mem_b(rsp_addr);
        rsp_pend   <= 1'b0;
      end else rsp_wait <= rsp_wait - 1;
    end
    if (sto_req && sto_gnt) begin
      rsp_pend <= 1'b1;
      rsp_addr <= sto_addr;
      rsp_wait <= lat;
    end
  end

  // monitor, sampled on the falling edge
  int cyc = 0, hi_n = 0, lo_n = 0, done_n = 0, retry_n = 0, acc_n = 0;
  int lo_cyc = 0, done_cyc = 0, hold_err = 0, ovl_err = 0;
  logic [7:0] hi_d, lo_d;
  logic hi_cpu, lo_cpu;
  logic [SW-2:0] hi_idx, lo_idx;
  logic [AW-1:0] acc_a0, acc_a1, prev_addr;
  logic prev_req = 1'b0, prev_gnt = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (lsr_wr_hi || att_wr_hi) begin
      hi_n++; hi_d = wr_data; hi_cpu = lsr_wr_hi; hi_idx = wr_index;
    end
    if (lsr_wr_lo || att_wr_lo) begin
      lo_n++; lo_d = wr_data; lo_cpu = lsr_wr_lo; lo_idx = wr_index; lo_cyc = cyc;
    end
    if (done)  begin done_n++; done_cyc = cyc; end
    if (retry) retry_n++;
    if (sto_req) begin
      if (rsp_pend || sto_rvalid) ovl_err++;
      if (prev_req && !prev_gnt && sto_addr != prev_addr) hold_err++;
      if (sto_gnt) begin acc_a0 = acc_a1; acc_a1 = sto_addr; acc_n++; end
    end
    prev_req = sto_req; prev_gnt = sto_gnt; prev_addr = sto_addr;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic [AW-1:0] a, input logic [QW-1:0] q,
                          input logic [SW-1:0] s);
    @(negedge clk); #1;
    opnd_addr = a; qcode = q; reg_sel = s; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 200 && done_n == d0; i++) @(negedge clk);
    @(negedge clk); #1;
  endtask

  task automatic check_xfer(input logic [AW-1:0] a, input logic [SW-1:0] s,
                            input int h0, input int l0, input int d0, input int c0);
    chk(hi_n == h0 + 1, "R7 high strobe count", hi_n - h0, 1);
    chk(lo_n == l0 + 1, "R7 low strobe count", lo_n - l0, 1);
    chk(hi_d == mem_b(a), "R7 high byte", hi_d, mem_b(a));
    chk(lo_d == mem_b(a + 16'd1), "R7 low byte", lo_d, mem_b(a + 16'd1));
    chk(acc_n == c0 + 2, "R10 request count", acc_n - c0, 2);
    chk(acc_a0 == a, "R5 first address", acc_a0, a);
    chk(acc_a1 == a + 16'd1, "R6 second address", acc_a1, a + 16'd1);
    chk(hi_cpu == s[SW-1] && lo_cpu == s[SW-1], "R8 location", hi_cpu, s[SW-1]);
    chk(hi_idx == s[SW-2:0] && lo_idx == s[SW-2:0], "R8 index", lo_idx, s[SW-2:0]);
    chk(done_n == d0 + 1, "R9 done count", done_n - d0, 1);
    chk(done_cyc == lo_cyc + 1, "R9 done timing", done_cyc - lo_cyc, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!sto_req && !retry && !done, "R1 control idle", {sto_req, retry, done}, 0);
    chk(!(lsr_wr_hi | lsr_wr_lo | att_wr_hi | att_wr_lo), "R1 strobes idle",
        {lsr_wr_hi, lsr_wr_lo, att_wr_hi, att_wr_lo}, 0);
  endtask

  task automatic t_cpu_reg();
    int h0 = hi_n, l0 = lo_n, d0 = done_n, c0 = acc_n;
    stall_cfg = 0; lat = 0;
    start_op(16'h1230, 8'h11, 4'b1101);
    wait_done(d0);
    check_xfer(16'h1230, 4'b1101, h0, l0, d0, c0);
  endtask

  task automatic t_attach_wrap();
    int h0 = hi_n, l0 = lo_n, d0 = done_n, c0 = acc_n;
    stall_cfg = 3; lat = 2;
    start_op(16'hFFFF, 8'h42, 4'b0011);
    wait_done(d0);
    check_xfer(16'hFFFF, 4'b0011, h0, l0, d0, c0);
    chk(hold_err == 0, "R5 hold under stall", hold_err, 0);
    stall_cfg = 0; lat = 0;
  endtask

  task automatic t_noop();
    int h0 = hi_n, d0 = done_n, c0 = acc_n, r0 = retry_n, sc;
    dev_busy = 1'b1;
    sc = cyc;
    start_op(16'h0500, 8'h00, 4'b1000);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk(done_n == d0 + 1, "R3 single done", done_n - d0, 1);
    chk(done_cyc == sc + 3, "R3 done timing", done_cyc - sc, 3);
    chk(acc_n == c0 && hi_n == h0, "R3 no access", acc_n - c0, 0);
    chk(retry_n == r0, "R3 no retry", retry_n - r0, 0);
    dev_busy = 1'b0;
  endtask

  task automatic t_retry();
    int h0 = hi_n, l0 = lo_n, d0 = done_n, c0 = acc_n, r0 = retry_n;
    dev_busy = 1'b1;
    start_op(16'h2468, 8'h07, 4'b1010);
    for (int i = 0; i < 3; i++) @(negedge clk);
    #1; dev_busy = 1'b0; dev_attn = 1'b1;
    for (int i = 0; i < 2; i++) @(negedge clk);
    #1;
    chk(acc_n == c0, "R4 no request while blocked", acc_n - c0, 0);
    dev_attn = 1'b0;
    wait_done(d0);
    chk(retry_n == r0 + 6, "R4 retry cycles", retry_n - r0, 6);
    check_xfer(16'h2468, 4'b1010, h0, l0, d0, c0);
  endtask

  task automatic t_ignore_start();
    int h0 = hi_n, l0 = lo_n, d0 = done_n, c0 = acc_n;
    lat = 1;
    start_op(16'h3ABC, 8'h09, 4'b0110);
    @(negedge clk); #1;
    opnd_addr = 16'h4000; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    wait_done(d0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    check_xfer(16'h3ABC, 4'b0110, h0, l0, d0, c0);
    chk(acc_n == c0 + 2, "R2 no extra instruction", acc_n - c0, 2);
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) @(posedge clk);
    @(negedge clk); #1; rst = 1'b0;
    t_reset();
    t_cpu_reg();
    t_attach_wrap();
    t_noop();
    t_retry();
    t_ignore_start();
    chk(ovl_err == 0, "R10 one outstanding", ovl_err, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule